// File: doc/BRIEF.md
# Beam-position H/V interrupt timer

This block raises a timer interrupt when the raster beam reaches a programmed point. It watches a horizontal position counter that advances in master-clock units and a vertical line counter, both driven from outside. A two-bit mode field selects one of four conditions: no interrupt, a horizontal point on every line, a fixed early point on one chosen line, or a horizontal point on one chosen line. The horizontal match point is not the raw target value. It is computed as the target times four plus eighteen master clocks. When no horizontal condition applies, or when the horizontal target is zero, the match point is a fixed position of fourteen.

A match sets a sticky pending flag. The active-low interrupt output is driven straight from that flag, so the readable status bit and the interrupt line change in the same cycle. A read strobe from the status-register decode returns the flag in bit 7 and clears it. Selecting the "off" mode also clears it. Bus decode and the processor's interrupt sequencing sit outside this block.

Top module: `irq_beam_timer`

## Requirements
- R1: While reset is active, and for two clocks after it is released, `irq_n` is 1 and `stat_flag` is 0.
- R2: With `irq_mode` = 2'b00 the interrupt never fires, whatever the beam position and targets are.
- R3: With `irq_mode` = 2'b01 and `htarget` nonzero, the flag is set on every line, in the cycle after `hpos` equals `htarget*4+18`.
- R4: With `irq_mode` = 2'b01 and `htarget` = 0, the match position is `hpos` = 14.
- R5: With `irq_mode` = 2'b10, the flag is set only on the line where `vpos` equals `vtarget`, at `hpos` = 14, and `htarget` is ignored.
- R6: With `irq_mode` = 2'b11, the flag is set only when `vpos` equals `vtarget` and `hpos` equals `htarget*4+18`.
- R7: `irq_n` is always the inverse of `stat_flag`, with no cycle offset. `status_data` carries the flag in bit 7 and zero in bits 6..0.
- R8: A `status_rd` pulse with no match in the same cycle clears the flag and releases `irq_n` high on the next clock.
- R9: A match in the same cycle as `status_rd` wins, so the flag is 1 afterwards.
- R10: Setting `irq_mode` to 2'b00 clears a pending flag on the next clock.
- R11: A match fires at most once while the beam stays on the matching position. Holding `hpos` there after a read does not set the flag again.
- R12: Once set, the flag stays set until it is read or the mode is set to 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| hpos | input | 11 | Horizontal beam position in master clocks |
| vpos | input | 9 | Vertical line number |
| irq_mode | input | 2 | Trigger mode: 00 off, 01 horizontal, 10 vertical, 11 both |
| htarget | input | 9 | Horizontal target value |
| vtarget | input | 9 | Vertical target line |
| status_rd | input | 1 | Status-register read strobe; clears the flag |
| irq_n | output | 1 | Active-low interrupt request |
| stat_flag | output | 1 | Pending flag, readable status bit |
| status_data | output | 8 | Status read value, flag in bit 7 |

## Verification
The assertions check the following on every cycle:
- The "off" mode holds the line released.
- A read with no match clears the flag.
- A match always wins over a read in the same cycle.
- A held match does not fire twice.
- The flag stays set until it is read or the mode is set to "off".
- The line only falls after an internal fire.

Only the bench scenarios can show where the trigger falls on each line:
- the arithmetic `htarget*4+18` against the fixed point 14;
- that the vertical modes pick exactly the target line;
- that `htarget` is ignored in the vertical-only mode.

The bench checks these by recording the horizontal position at which `irq_n` first falls on each scanned line.

// File: rtl/irq_beam_pkg.sv
package irq_beam_pkg;

  typedef enum logic [1:0] {
    TRIG_OFF = 2'b00,
    TRIG_H   = 2'b01,
    TRIG_V   = 2'b10,
    TRIG_HV  = 2'b11
  } trig_mode_e;

  // horizontal point = target << H_SHIFT + H_OFFSET, else FIXED_POS
  localparam int unsigned H_SHIFT   = 2;
  localparam int unsigned H_OFFSET  = 18;
  localparam int unsigned FIXED_POS = 14;
  localparam int unsigned STAT_BIT  = 7;
  localparam int unsigned STAT_W    = 8;

  function automatic logic uses_h(trig_mode_e m);
    return (m == TRIG_H) || (m == TRIG_HV);
  endfunction

  function automatic logic uses_v(trig_mode_e m);
    return (m == TRIG_V) || (m == TRIG_HV);
  endfunction

endpackage

// File: rtl/irq_reset_sync.sv
module irq_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/irq_pos_calc.sv
module irq_pos_calc
  import irq_beam_pkg::*;
#(
  parameter int unsigned TW = 9,
  parameter int unsigned CW = 12
) (
  input  trig_mode_e    mode,
  input  logic [TW-1:0] htarget,
  output logic [CW-1:0] trig_pos
);
  logic          h_active;
  logic [CW-1:0] scaled;

  always_comb begin
    h_active = uses_h(mode) && (htarget != '0);
    scaled   = CW'(htarget) << H_SHIFT;
    if (h_active) trig_pos = scaled + CW'(H_OFFSET);
    else          trig_pos = CW'(FIXED_POS);
  end
endmodule

// File: rtl/irq_beam_cmp.sv
module irq_beam_cmp
  import irq_beam_pkg::*;
#(
  parameter int unsigned HW = 11,
  parameter int unsigned VW = 9,
  parameter int unsigned CW = 12
) (
  input  logic          clk,
  input  logic          srst_n,
  input  logic [HW-1:0] hpos,
  input  logic [VW-1:0] vpos,
  input  logic [VW-1:0] vtarget,
  input  trig_mode_e    mode,
  input  logic [CW-1:0] trig_pos,
  output logic          fire
);
  logic [CW-1:0] h_ext;
  logic          h_hit;
  logic          v_hit;
  logic          match_w;
  logic          prev_q;
  logic          prev_d;

  always_comb begin
    h_ext   = CW'(hpos);
    h_hit   = (h_ext == trig_pos);
    v_hit   = !uses_v(mode) || (vpos == vtarget);
    match_w = (mode != TRIG_OFF) && h_hit && v_hit;
    prev_d  = match_w;
    fire    = match_w && !prev_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) prev_q <= 1'b0;
    else         prev_q <= prev_d;
  end
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg (
  input  logic clk,
  input  logic srst_n,
  input  logic fire,
  input  logic rd_clear,
  input  logic off_clear,
  output logic flag
);
  logic flag_q;
  logic flag_d;
  logic flag_en;

  always_comb begin
    flag_en = fire || rd_clear || off_clear;
    flag_d  = fire;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)      flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/irq_beam_timer.sv
module irq_beam_timer
  import irq_beam_pkg::*;
#(
  parameter int unsigned HW          = 11,
  parameter int unsigned VW          = 9,
  parameter int unsigned TW          = 9,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HW-1:0]     hpos,
  input  logic [VW-1:0]     vpos,
  input  logic [1:0]        irq_mode,
  input  logic [TW-1:0]     htarget,
  input  logic [VW-1:0]     vtarget,
  input  logic              status_rd,
  output logic              irq_n,
  output logic              stat_flag,
  output logic [STAT_W-1:0] status_data
);
  localparam int unsigned PW = TW + H_SHIFT + 1;
  localparam int unsigned CW = (HW > PW) ? HW : PW;

  logic          srst_n;
  trig_mode_e    mode_w;
  logic [CW-1:0] trig_pos;
  logic          fire_w;
  logic          off_w;
  logic          flag_w;

  assign mode_w = trig_mode_e'(irq_mode);
  assign off_w  = (mode_w == TRIG_OFF);

  irq_reset_sync #(.STAGES(SYNC_STAGES)) u_rsync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  irq_pos_calc #(.TW(TW), .CW(CW)) u_pos (
    .mode     (mode_w),
    .htarget  (htarget),
    .trig_pos (trig_pos)
  );

  irq_beam_cmp #(.HW(HW), .VW(VW), .CW(CW)) u_cmp (
    .clk      (clk),
    .srst_n   (srst_n),
    .hpos     (hpos),
    .vpos     (vpos),
    .vtarget  (vtarget),
    .mode     (mode_w),
    .trig_pos (trig_pos),
    .fire     (fire_w)
  );

  irq_flag_reg u_flag (
    .clk       (clk),
    .srst_n    (srst_n),
    .fire      (fire_w),
    .rd_clear  (status_rd),
    .off_clear (off_w),
    .flag      (flag_w)
  );

  always_comb begin
    stat_flag             = flag_w;
    irq_n                 = !flag_w;
    status_data           = '0;
    status_data[STAT_BIT] = flag_w;
  end
endmodule

// File: rtl/irq_beam_timer_chk.sv
module irq_beam_timer_chk (
  input logic       clk,
  input logic       srst_n,
  input logic [1:0] irq_mode,
  input logic       status_rd,
  input logic       fire,
  input logic       irq_n,
  input logic       stat_flag
);
  // R2, R10: off mode leaves the line released next cycle
  assert_off_quiet_R2: assert property (@(posedge clk) disable iff (!srst_n)
    (irq_mode == 2'b00) |=> irq_n);

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!srst_n)
    (status_rd && !fire) |=> !stat_flag);

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!srst_n)
    fire |=> (!irq_n && stat_flag));

  assert_single_fire_R11: assert property (@(posedge clk) disable iff (!srst_n)
    fire |=> !fire);

  assert_sticky_R12: assert property (@(posedge clk) disable iff (!srst_n)
    (stat_flag && !status_rd && irq_mode != 2'b00) |=> stat_flag);

  assert_fall_needs_fire_R7: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(irq_n) |-> ($past(fire) && $rose(stat_flag)));
endmodule

bind irq_beam_timer irq_beam_timer_chk u_chk (
  .clk       (clk),
  .srst_n    (srst_n),
  .irq_mode  (irq_mode),
  .status_rd (status_rd),
  .fire      (fire_w),
  .irq_n     (irq_n),
  .stat_flag (stat_flag)
);

// File: tb/test_irq_beam_timer.sv
module test_irq_beam_timer;
  localparam int LINE = 80;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [10:0] hpos;
  logic [8:0]  vpos;
  logic [1:0]  irq_mode;
  logic [8:0]  htarget;
  logic [8:0]  vtarget;
  logic        status_rd;
  logic        irq_n;
  logic        stat_flag;
  logic [7:0]  status_data;

  int    errors = 0;
  int    checks = 0;
  string cur_req = "R1";
  bit    cmp_en = 0;
  bit    done = 0;
  int    fall_h;
  int    drv_h = 0;
  logic  last_irq = 1'b1;

  // reference model state
  int m_flag = 0;
  int m_prev = 0;
  int rcnt = 0;

  always #2 clk = ~clk;

  irq_beam_timer i_irq_beam_timer (
    .clk(clk), .rst_n(rst_n), .hpos(hpos), .vpos(vpos), .irq_mode(irq_mode),
    .htarget(htarget), .vtarget(vtarget), .status_rd(status_rd),
    .irq_n(irq_n), .stat_flag(stat_flag), .status_data(status_data)
  );

  always @(posedge clk) begin
    int tp;
    bit hit;
    bit f;
    if (!rst_n) begin
      rcnt = 0; m_flag = 0; m_prev = 0;
    end else if (rcnt < 2) begin
      rcnt++; m_flag = 0; m_prev = 0;
    end else begin
      tp  = (irq_mode[0] && htarget != 0) ? int'(htarget) * 4 + 18 : 14;
      hit = (irq_mode != 2'b00) && (int'(hpos) == tp) &&
            (!irq_mode[1] || vpos == vtarget);
      f   = hit && (m_prev == 0);
      m_prev = hit;
      if (f) m_flag = 1;
      else if (status_rd || irq_mode == 2'b00) m_flag = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cmp_cycle();
    chk(irq_n == (m_flag == 0), cur_req, int'(irq_n), int'(m_flag == 0));
    chk(stat_flag == (m_flag != 0), cur_req, int'(stat_flag), m_flag);
    chk(status_data == {m_flag[0], 7'b0}, "R7", int'(status_data), m_flag * 128);
  endtask

  task automatic step(input int h, input int v, input bit rd);
    @(negedge clk);
    if (cmp_en) cmp_cycle();
    if (irq_n === 1'b0 && last_irq === 1'b1 && fall_h < 0) fall_h = drv_h;
    last_irq = irq_n;
    drv_h = h;
    hpos = 11'(h); vpos = 9'(v); status_rd = rd;
  endtask

  task automatic scan_line(input int v, input bit rd_end, input string req, input int exp);
    fall_h = -1;
    for (int h = 0; h < LINE; h++) step(h, v, rd_end && (h == LINE - 1));
    step(0, v, 1'b0);
    chk(fall_h == exp, req, fall_h, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; hpos = '0; vpos = '0; irq_mode = 2'b01; htarget = 9'd3;
    vtarget = '0; status_rd = 1'b0;
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk(irq_n == 1'b1, "R1", int'(irq_n), 1);
    chk(stat_flag == 1'b0, "R1", int'(stat_flag), 0);
    cmp_en = 1;
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(0, 0, 1'b0);

    cur_req = "R2"; irq_mode = 2'b00; htarget = 9'd5; vtarget = 9'd0;
    for (int v = 0; v < 3; v++) scan_line(v, 1'b1, "R2", -1);

    cur_req = "R3"; irq_mode = 2'b01; htarget = 9'd5;
    for (int v = 0; v < 3; v++) scan_line(v, 1'b1, "R3", 38);
    htarget = 9'd15;
    scan_line(3, 1'b1, "R3", 78);

    cur_req = "R4"; htarget = 9'd0;
    for (int v = 0; v < 2; v++) scan_line(v, 1'b1, "R4", 14);

    cur_req = "R5"; irq_mode = 2'b10; htarget = 9'd9; vtarget = 9'd3;
    for (int v = 0; v < 5; v++) scan_line(v, 1'b1, "R5", (v == 3) ? 14 : -1);

    cur_req = "R6"; irq_mode = 2'b11; htarget = 9'd7; vtarget = 9'd2;
    for (int v = 0; v < 4; v++) scan_line(v, 1'b1, "R6", (v == 2) ? 46 : -1);

    cur_req = "R12"; irq_mode = 2'b01; htarget = 9'd4;
    scan_line(0, 1'b0, "R12", 34);
    scan_line(1, 1'b0, "R12", -1);
    chk(stat_flag == 1'b1, "R12", int'(stat_flag), 1);

    cur_req = "R8";
    step(0, 0, 1'b1); step(1, 0, 1'b0);
    chk(stat_flag == 1'b0 && irq_n == 1'b1, "R8", int'(stat_flag), 0);

    cur_req = "R9";
    step(34, 0, 1'b1); step(35, 0, 1'b0);
    chk(stat_flag == 1'b1 && irq_n == 1'b0, "R9", int'(stat_flag), 1);

    cur_req = "R11";
    step(0, 0, 1'b1); step(34, 0, 1'b0); step(34, 0, 1'b1);
    step(34, 0, 1'b0); step(34, 0, 1'b0); step(34, 0, 1'b0);
    chk(stat_flag == 1'b0, "R11", int'(stat_flag), 0);

    cur_req = "R10";
    step(0, 0, 1'b0); step(34, 0, 1'b0); step(35, 0, 1'b0);
    chk(irq_n == 1'b0, "R10", int'(irq_n), 0);
    irq_mode = 2'b00;
    step(36, 0, 1'b0);
    chk(irq_n == 1'b1 && stat_flag == 1'b0, "R10", int'(irq_n), 1);
    irq_mode = 2'b01;
    step(37, 0, 1'b0); step(38, 0, 1'b0);
    chk(irq_n == 1'b1, "R10", int'(irq_n), 1);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule